// File: doc/BRIEF.md
# Idle-Downshift Power Mode Controller

This block chooses how often a motion sensor samples its surface. It starts at full rate (Run), where it samples once per frame. While no motion is seen, it steps down through three rest modes. Each rest mode samples less often than the one before: current draw falls, and the delay before the sensor reacts to new motion grows. Any detected motion brings it straight back to Run.

The frame clock and the slow rest clock are generated elsewhere and arrive as single-cycle strobes. A small write port sets the timing of each mode. Software can also pin the controller in one chosen rest mode. While pinned, automatic downshift and wake on motion are both suspended.

The controller raises a one-cycle sampling strobe whenever the sensing logic should take a sample. It also reports the active mode, both as a 2-bit code and as a byte with the mode in its two top bits.

Top module: `idle_pwr_mode_ctrl`

## Requirements
- R1: Mode codes are 0 = Run, 1 = Rest1, 2 = Rest2 and 3 = Rest3. With no motion and no forcing, the mode advances only Run, then Rest1, then Rest2, then Rest3. Rest3 is held indefinitely.
- R2: Run mode falls to Rest1 on the (run value × 16)-th frame strobe counted from entry into Run or from the last motion. The run value resets to 0x46. A stored value of 0 acts as 1.
- R3: A rest period lasts (period value + 1) slow-tick strobes. The period values reset to 0x00 for Rest1, 0x09 for Rest2 and 0x31 for Rest3.
- R4: Rest1 falls to Rest2 after (Rest1 downshift value × 16) Rest1 periods. Rest2 falls to Rest3 after (Rest2 downshift value × 128) Rest2 periods. These values reset to 0x4F and 0x2F. A rest downshift value of 0 holds that rest mode.
- R5: Any value written above 0xFD to a timing register is stored as 0xFD.
- R6: When not forced, a motion pulse in any mode puts the controller in Run on the next cycle and restarts the Run timeout.
- R7: In Run, `sample_stb` is high in the cycle after each frame strobe. In a rest mode, it is high in the cycle after the slow tick that completes a period. It is low at all other times.
- R8: Writing a non-zero value to bits 7:6 of the mode register forces that rest mode on the next cycle. While forced, motion and the downshift timeouts have no effect, but period strobes continue.
- R9: Writing 00 to bits 7:6 of the mode register returns the controller to Run with automatic operation. `mode_rd` always equals the active mode in bits 7:6, with bits 5:0 zero.
- R10: The write addresses are as follows:
  - 0: Run downshift
  - 1: Rest1 period
  - 2: Rest1 downshift
  - 3: Rest2 period
  - 4: Rest2 downshift
  - 5: Rest3 period
  - 6: mode register

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame period |
| slow_tick | input | 1 | One-cycle strobe from the slow rest clock |
| motion | input | 1 | One-cycle pulse when motion is detected |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | AW (3) | Register write address |
| wr_data | input | DW (8) | Register write data |
| mode | output | 2 | Active power mode code |
| sample_stb | output | 1 | One-cycle sampling strobe |
| mode_rd | output | DW (8) | Readable mode field, mode in bits 7:6 |

## Verification
The hardest state to reach is Rest3. Getting there needs thousands of frame strobes followed by tens of thousands of slow ticks at reset timing. Because of that, the stimulus first checks the Run and Rest1 timeouts at their reset values.

It then writes small random timing values to reach Rest2 and Rest3 within a few hundred ticks. Each boundary is checked on the exact strobe where the mode must change, using tick counts computed from the register values.

Forcing is used to measure the Rest2, Rest3 and clamped periods directly, without waiting for a downshift.

// File: rtl/idle_pwr_mode_ctrl.sv
module idle_pwr_mode_ctrl #(
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter int RUN_SCALE = 16,
  parameter int R1_SCALE  = 16,
  parameter int R2_SCALE  = 128,
  parameter int REG_MAX   = 253
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          slow_tick,
  input  logic          motion,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    mode,
  output logic          sample_stb,
  output logic [DW-1:0] mode_rd
);

  localparam int FCW = $clog2(REG_MAX * RUN_SCALE + 1);
  localparam int DCW = $clog2(REG_MAX * (R1_SCALE > R2_SCALE ? R1_SCALE : R2_SCALE) + 1);
  localparam logic [DW-1:0] SAT = DW'(REG_MAX);

  localparam logic [1:0] M_RUN = 2'd0;
  localparam logic [1:0] M_R1  = 2'd1;
  localparam logic [1:0] M_R2  = 2'd2;
  localparam logic [1:0] M_R3  = 2'd3;

  localparam logic [AW-1:0] A_RUN_DS = AW'(0);
  localparam logic [AW-1:0] A_R1_PER = AW'(1);
  localparam logic [AW-1:0] A_R1_DS  = AW'(2);
  localparam logic [AW-1:0] A_R2_PER = AW'(3);
  localparam logic [AW-1:0] A_R2_DS  = AW'(4);
  localparam logic [AW-1:0] A_R3_PER = AW'(5);
  localparam logic [AW-1:0] A_MODE   = AW'(6);

  logic [DW-1:0]  run_ds, r1_per, r1_ds, r2_per, r2_ds, r3_per;
  logic [1:0]     force_md, mode_q;
  logic [FCW-1:0] fcnt;
  logic [DCW-1:0] dcnt;
  logic [DW-1:0]  pcnt;
  logic [DW-1:0]  cur_per;
  logic [FCW-1:0] run_lim;
  logic [DCW-1:0] rest_lim;
  logic           per_done, run_to, rest_to;

  wire          wr_mode = wr_en && (wr_addr == A_MODE);
  wire [1:0]    wr_md   = wr_data[DW-1 -: 2];
  wire [DW-1:0] wsat    = (wr_data > SAT) ? SAT : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_ds   <= DW'(8'h46);
      r1_per   <= DW'(8'h00);
      r1_ds    <= DW'(8'h4F);
      r2_per   <= DW'(8'h09);
      r2_ds    <= DW'(8'h2F);
      r3_per   <= DW'(8'h31);
      force_md <= M_RUN;
    end else if (wr_en) begin
      case (wr_addr)
        A_RUN_DS: run_ds   <= (wsat == '0) ? DW'(1) : wsat;
        A_R1_PER: r1_per   <= wsat;
        A_R1_DS:  r1_ds    <= wsat;
        A_R2_PER: r2_per   <= wsat;
        A_R2_DS:  r2_ds    <= wsat;
        A_R3_PER: r3_per   <= wsat;
        A_MODE:   force_md <= wr_md;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (mode_q)
      M_R1:    cur_per = r1_per;
      M_R2:    cur_per = r2_per;
      default: cur_per = r3_per;
    endcase
  end

  assign run_lim  = FCW'(run_ds) * FCW'(RUN_SCALE);
  assign rest_lim = (mode_q == M_R1) ? DCW'(r1_ds) * DCW'(R1_SCALE)
                                     : DCW'(r2_ds) * DCW'(R2_SCALE);
  assign per_done = (mode_q != M_RUN) && slow_tick && (pcnt >= cur_per);
  assign run_to   = (mode_q == M_RUN) && frame_tick &&
                    ((FCW+1)'(fcnt) + (FCW+1)'(1) >= (FCW+1)'(run_lim));
  assign rest_to  = per_done && (mode_q == M_R1 || mode_q == M_R2) && (rest_lim != '0) &&
                    ((DCW+1)'(dcnt) + (DCW+1)'(1) >= (DCW+1)'(rest_lim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= M_RUN;
      fcnt       <= '0;
      dcnt       <= '0;
      pcnt       <= '0;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= (mode_q == M_RUN) ? frame_tick : per_done;
      if (wr_mode) begin
        mode_q <= wr_md;
        fcnt   <= '0;
        dcnt   <= '0;
        pcnt   <= '0;
      end else if (force_md != M_RUN) begin
        fcnt <= '0;
        dcnt <= '0;
        if (per_done)       pcnt <= '0;
        else if (slow_tick) pcnt <= pcnt + 1'b1;
      end else if (motion || run_to || rest_to) begin
        mode_q <= motion ? M_RUN : mode_q + 2'd1;
        fcnt   <= '0;
        dcnt   <= '0;
        pcnt   <= '0;
      end else if (mode_q == M_RUN) begin
        if (frame_tick) fcnt <= fcnt + 1'b1;
      end else if (per_done) begin
        pcnt <= '0;
        if (mode_q != M_R3) dcnt <= dcnt + 1'b1;
      end else if (slow_tick) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign mode    = mode_q;
  assign mode_rd = {mode_q, {(DW-2){1'b0}}};

  AST_MOTION_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (motion && !wr_mode && force_md == M_RUN) |=> (mode == M_RUN)); // R6
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (force_md != M_RUN && !wr_mode) |=> $stable(mode)); // R8
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && !motion) |=> (mode == $past(mode) || mode == 2'($past(mode) + 2'd1))); // R1
  AST_REST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_RUN && !slow_tick) |=> !sample_stb); // R7
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_rd[DW-1 -: 2] == $past(wr_md))); // R9

endmodule

// File: tb/test_idle_pwr_mode_ctrl.sv
module test_idle_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0, slow_tick = 1'b0, motion = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode;
  logic       sample_stb;
  logic [7:0] mode_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idle_pwr_mode_ctrl i_idle_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .slow_tick(slow_tick),
    .motion(motion), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .sample_stb(sample_stb), .mode_rd(mode_rd)
  );

  function automatic int sat(int v); return (v > 253) ? 253 : v; endfunction
  function automatic int run_frames(int v); return ((sat(v) == 0) ? 1 : sat(v)) * 16; endfunction
  function automatic int per_ticks(int v); return sat(v) + 1; endfunction
  function automatic int r1_ticks(int d, int p); return sat(d) * 16 * per_ticks(p); endfunction
  function automatic int r2_ticks(int d, int p); return sat(d) * 128 * per_ticks(p); endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit f, input bit s, input bit m);
    frame_tick = f; slow_tick = s; motion = m;
    @(negedge clk);
    frame_tick = 1'b0; slow_tick = 1'b0; motion = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frames(input int n, output int nstb);
    nstb = 0;
    for (int i = 0; i < n; i++) begin cyc(1'b1, 1'b0, 1'b0); if (sample_stb) nstb++; end
  endtask

  task automatic ticks(input int n, output int nstb);
    nstb = 0;
    for (int i = 0; i < n; i++) begin cyc(1'b0, 1'b1, 1'b0); if (sample_stb) nstb++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int s;
    void'($urandom(32'd7215));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "reset mode", int'(mode), 0);
    check("R9", "reset mode_rd", int'(mode_rd), 0);
    check("R7", "reset strobe", int'(sample_stb), 0);

    cyc(1'b1, 1'b0, 1'b0);
    check("R7", "run frame strobe", int'(sample_stb), 1);
    cyc(1'b0, 1'b1, 1'b0);
    check("R7", "run slow tick no strobe", int'(sample_stb), 0);

    // R2 default 0x46*16 frames (one already spent above)
    frames(run_frames(8'h46) - 2, s);
    check("R2", "default run still Run", int'(mode), 0);
    check("R7", "run strobe count", s, run_frames(8'h46) - 2);
    cyc(1'b1, 1'b0, 1'b0);
    check("R2", "default run timeout", int'(mode), 1);

    cyc(1'b0, 1'b1, 1'b0);
    check("R3", "rest1 default period strobe", int'(sample_stb), 1);
    cyc(1'b1, 1'b0, 1'b0);
    check("R7", "frame in rest no strobe", int'(sample_stb), 0);
    cyc(1'b0, 1'b0, 1'b1);
    check("R6", "motion wakes rest1", int'(mode), 0);

    // R8 forced Rest2 measures default period
    wr(6, 8'h80);
    check("R8", "force rest2", int'(mode), 2);
    check("R9", "mode_rd forced", int'(mode_rd), 8'h80);
    ticks(per_ticks(8'h09) - 1, s);
    check("R3", "rest2 default no early strobe", s, 0);
    ticks(1, s);
    check("R3", "rest2 default period strobe", s, 1);
    cyc(1'b0, 1'b0, 1'b1);
    check("R8", "motion ignored when forced", int'(mode), 2);
    wr(6, 8'hC0);
    ticks(per_ticks(8'h31) - 1, s);
    check("R3", "rest3 default no early strobe", s, 0);
    ticks(1, s);
    check("R3", "rest3 default period strobe", s, 1);
    wr(6, 8'h00);
    check("R9", "release to Run", int'(mode), 0);

    // R4 default Rest1 downshift
    frames(run_frames(8'h46), s);
    check("R2", "run timeout after release", int'(mode), 1);
    ticks(r1_ticks(8'h4F, 0) - 1, s);
    check("R4", "default rest1 still Rest1", int'(mode), 1);
    ticks(1, s);
    check("R4", "default rest1 downshift", int'(mode), 2);

    // R5 saturation: run 0 acts as 1, period 0xFF acts as 0xFD
    wr(0, 8'h00);
    cyc(1'b0, 1'b0, 1'b1);
    frames(15, s);
    check("R2", "run value 0 treated as 1, before", int'(mode), 0);
    frames(1, s);
    check("R2", "run value 0 treated as 1, timeout", int'(mode), 1);
    wr(5, 8'hFF);
    wr(6, 8'hC0);
    ticks(253, s);
    check("R5", "clamped period no early strobe", s, 0);
    ticks(1, s);
    check("R5", "clamped period strobe at 254", s, 1);
    wr(6, 8'h00);

    // R4 rest downshift 0 holds
    wr(1, 0); wr(2, 0);
    frames(16, s);
    check("R1", "to Rest1", int'(mode), 1);
    ticks(300, s);
    check("R4", "rest1 downshift 0 holds", int'(mode), 1);

    // R6 motion restarts run timeout
    cyc(1'b0, 1'b0, 1'b1);
    frames(10, s);
    cyc(1'b0, 1'b0, 1'b1);
    check("R6", "motion in Run stays Run", int'(mode), 0);
    frames(15, s);
    check("R6", "run timeout restarted", int'(mode), 0);
    frames(1, s);
    check("R6", "restarted timeout expires", int'(mode), 1);

    // R10 randomized full walk
    for (int t = 0; t < 20; t++) begin
      int rd, p1, d1, p2, d2, p3;
      rd = (t % 4 == 0) ? 0 : 1 + int'($urandom % 4);
      p1 = int'($urandom % 4); d1 = 1 + int'($urandom % 3);
      p2 = int'($urandom % 3); d2 = 1 + int'($urandom % 2);
      p3 = int'($urandom % 3);
      wr(0, rd); wr(1, p1); wr(2, d1); wr(3, p2); wr(4, d2); wr(5, p3);
      cyc(1'b0, 1'b0, 1'b1);
      check("R6", "rand wake", int'(mode), 0);
      n = run_frames(rd);
      frames(n - 1, s);
      check("R2", "rand run before", int'(mode), 0);
      frames(1, s);
      check("R10", "rand run timeout", int'(mode), 1);
      n = r1_ticks(d1, p1);
      ticks(n - 1, s);
      check("R4", "rand rest1 before", int'(mode), 1);
      check("R7", "rand rest1 strobes", s, n / per_ticks(p1) - 1);
      ticks(1, s);
      check("R4", "rand rest1 timeout", int'(mode), 2);
      n = r2_ticks(d2, p2);
      ticks(n - 1, s);
      check("R4", "rand rest2 before", int'(mode), 2);
      ticks(1, s);
      check("R4", "rand rest2 timeout", int'(mode), 3);
      ticks(2 * per_ticks(p3), s);
      check("R1", "rand rest3 holds", int'(mode), 3);
      check("R3", "rand rest3 strobes", s, 2);
      check("R9", "rand mode_rd", int'(mode_rd), 8'hC0);
    end
    cyc(1'b0, 1'b0, 1'b1);
    check("R6", "final wake from Rest3", int'(mode), 0);
    finish_run();
  end
endmodule